// File: doc/BRIEF.md
# Dual-Issue In-Order Scoreboard

This block is the issue controller for a two-wide, in-order pipeline with three execution units: a two-cycle multiplier, a two-cycle divider and a one-cycle add/subtract unit. A decoder hands it a pair of instructions. Each instruction carries an operation class, a destination register, two source registers and a tag. The controller holds the pair in two decode slots. Each cycle it decides which instructions leave for their unit, follows every in-flight operation to its writeback, and reports each writeback on one of two result ports.

The block carries no data values; it produces only timing. A free-running cycle counter, together with the per-slot issue strobes and per-port writeback strobes (each with the instruction tag), lets an observer rebuild the issue cycle and the write cycle of every instruction.

Issue is strictly in program order. Any register hazard between an instruction and older work stops that instruction and everything behind it. Hazards checked are read-after-write, write-after-write and write-after-read. Results are never written back ahead of an older instruction's result.

Top module: `dual_issue_scoreboard`

## Requirements
- R1: While reset is held, the cycle counter reads 0, `in_ready` is high and no issue or writeback strobe is active.
- R2: A new pair is taken only in a cycle where `in_ready` is high, and `in_ready` is high only when both decode slots are empty. A pair offered while either slot still holds an instruction is dropped and never issues.
- R3: Operation class encoding is 0 multiply, 1 divide, 2 add, 3 subtract. An accepted instruction can issue at the earliest in the cycle after acceptance. Add and subtract write back one cycle after issue; multiply and divide write back two cycles after issue.
- R4: The multiplier and the divider each start a new operation no sooner than two cycles after the previous one. Two instructions for the same unit never issue in the same cycle.
- R5: An instruction that reads a register with a write still in flight issues at the earliest one cycle after that write's writeback.
- R6: An instruction whose destination has a write still in flight waits until the cycle after that writeback.
- R7: When the younger slot's destination equals a source of the older slot, the younger one does not issue in the same cycle as the older one.
- R8: The younger slot never issues before the older one. When the older slot is stalled, the younger stalls too, even if it is otherwise free to go.
- R9: A younger instruction's writeback never occurs in an earlier cycle than an older instruction's writeback. An add issued alongside an older two-cycle operation is held back one cycle.
- R10: At most two writebacks occur per cycle. When two occur together, port 0 carries the older instruction.
- R11: The cycle counter advances by exactly one every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decode pair is offered |
| in_ready | output | 1 | Both decode slots are empty; the offered pair is taken |
| in_slot_v | input | 2 | Per-slot valid of the offered pair (bit 0 is older) |
| in_op | input | 4 | Operation class per slot, 2 bits each |
| in_dst | input | 2*REG_W | Destination register per slot |
| in_src_a | input | 2*REG_W | First source register per slot |
| in_src_b | input | 2*REG_W | Second source register per slot |
| in_id | input | 2*ID_W | Instruction tag per slot |
| iss_v | output | 2 | Slot issues this cycle |
| iss_id | output | 2*ID_W | Tag of each slot's instruction |
| wb_v | output | 2 | Writeback port active |
| wb_dst | output | 2*REG_W | Register written on each port |
| wb_id | output | 2*ID_W | Tag of the instruction written on each port |
| cycle | output | CYC_W | Cycles since reset |

## Verification
The bench aims at the one-cycle gap rules. A read-after-write consumer must start one cycle after the producer's writeback, not in the same cycle; an off-by-one there lets a consumer read a stale value. A write-after-write pair must wait for the first write to finish, or the two results land in the wrong order. A younger write-after-read pair that issues alongside its older neighbour would clobber an operand before it is read. An add paired behind a multiply must slip one cycle; a design that lets it go together retires the add first. Other targets are the tie order on the two writeback ports and a younger slot that must not pass a stalled head. Two back-to-back multiplies must respect the busy cycle. Finally, a pair offered while a slot is still occupied must be lost rather than overwrite the waiting instruction.

// File: rtl/dis_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-issue scoreboard: operation classes,
// execution unit identifiers and the class-to-unit mapping.
package dis_pkg;

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_DIV = 2'd1,
        OP_ADD = 2'd2,
        OP_SUB = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        UNIT_MUL = 2'd0,
        UNIT_DIV = 2'd1,
        UNIT_ALU = 2'd2
    } unit_e;

    localparam int NUM_SLOTS = 2;
    localparam int NUM_LONG  = 2;

    // Which unit executes a given operation class.
    function automatic unit_e unit_of(input logic [1:0] op);
        case (op)
            2'd0:    return UNIT_MUL;
            2'd1:    return UNIT_DIV;
            default: return UNIT_ALU;
        endcase
    endfunction

    // Two-cycle operations (multiply, divide) versus one-cycle (add, sub).
    function automatic logic is_long(input logic [1:0] op);
        return (op[1] == 1'b0);
    endfunction

endpackage

// File: rtl/dis_decode_slots.sv
`timescale 1ns/1ps
// Two-entry decode buffer. Slot 0 holds the older instruction.
// Assumes: a pair is loaded only when both slots are empty; a slot is
// vacated in the cycle its issue strobe is high.
module dis_decode_slots #(
    parameter int REG_W = 3,
    parameter int ID_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [1:0]                 in_slot_v,
    input  logic [1:0][1:0]            in_op,
    input  logic [1:0][REG_W-1:0]      in_dst,
    input  logic [1:0][REG_W-1:0]      in_src_a,
    input  logic [1:0][REG_W-1:0]      in_src_b,
    input  logic [1:0][ID_W-1:0]       in_id,
    input  logic [1:0]                 issue,
    output logic [1:0]                 slot_v,
    output logic [1:0][1:0]            slot_op,
    output logic [1:0][REG_W-1:0]      slot_dst,
    output logic [1:0][REG_W-1:0]      slot_sa,
    output logic [1:0][REG_W-1:0]      slot_sb,
    output logic [1:0][ID_W-1:0]       slot_id
);

    // The pair may enter only after both entries have left.
    assign in_ready = (slot_v == 2'b00);

    // Load a new pair or retire issued entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v <= 2'b00;
        end else if (in_valid && in_ready) begin
            slot_v   <= in_slot_v;
            slot_op  <= in_op;
            slot_dst <= in_dst;
            slot_sa  <= in_src_a;
            slot_sb  <= in_src_b;
            slot_id  <= in_id;
        end else begin
            slot_v <= slot_v & ~issue;
        end
    end

    AST_PAIR_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_v[0]) |-> (!$past(slot_v[1]) || $past(issue[1])));  // R2

endmodule

// File: rtl/dis_pend_table.sv
`timescale 1ns/1ps
// Per-register pending-write bits. A bit is set when a writer issues
// and cleared when its result is written back.
// Assumes: a register is never set while already pending.
module dis_pend_table #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             set_v,
    input  logic [1:0][REG_W-1:0]  set_idx,
    input  logic [1:0]             clr_v,
    input  logic [1:0][REG_W-1:0]  clr_idx,
    output logic [NUM_REGS-1:0]    pend
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic set_hit;
        logic clr_hit;

        // Decode whether this register is written or retired this cycle.
        always_comb begin
            set_hit = 1'b0;
            clr_hit = 1'b0;
            for (int k = 0; k < 2; k++) begin
                if (set_v[k] && (set_idx[k] == REG_W'(r))) set_hit = 1'b1;
                if (clr_v[k] && (clr_idx[k] == REG_W'(r))) clr_hit = 1'b1;
            end
        end

        // Hold the pending bit for this register.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[r] <= 1'b0;
            else        pend[r] <= (pend[r] & ~clr_hit) | set_hit;
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_chk
        AST_NO_DOUBLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[k] |-> !pend[set_idx[k]]);  // R6
        AST_RETIRE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            clr_v[k] |-> pend[clr_idx[k]]);  // R5
    end

endmodule

// File: rtl/dis_long_pipe.sv
`timescale 1ns/1ps
// Two-stage non-pipelined unit model (multiply or divide): an operation
// occupies the unit for the cycle after issue and completes one cycle later.
// Assumes: go is never raised while busy.
module dis_long_pipe #(
    parameter int REG_W = 3,
    parameter int ID_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [REG_W-1:0] go_dst,
    input  logic [ID_W-1:0]  go_id,
    input  logic             go_young,
    output logic             busy,
    output logic             done_v,
    output logic [REG_W-1:0] done_dst,
    output logic [ID_W-1:0]  done_id,
    output logic             done_young
);

    logic             s1_v;
    logic [REG_W-1:0] s1_dst;
    logic [ID_W-1:0]  s1_id;
    logic             s1_young;

    // Advance the operation through its two cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            done_v <= 1'b0;
        end else begin
            s1_v       <= go;
            s1_dst     <= go_dst;
            s1_id      <= go_id;
            s1_young   <= go_young;
            done_v     <= s1_v;
            done_dst   <= s1_dst;
            done_id    <= s1_id;
            done_young <= s1_young;
        end
    end

    assign busy = s1_v;

    AST_UNIT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !s1_v);  // R4

endmodule

// File: rtl/dis_exec.sv
`timescale 1ns/1ps
// Execution timing for the three units and the two writeback ports.
// Ports are filled oldest first: of two simultaneous long results the one
// not marked younger goes first, and an add/sub result is always youngest.
module dis_exec #(
    parameter int REG_W = 3,
    parameter int ID_W  = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [dis_pkg::NUM_LONG-1:0]    go_long,
    input  logic [dis_pkg::NUM_LONG-1:0][REG_W-1:0] go_long_dst,
    input  logic [dis_pkg::NUM_LONG-1:0][ID_W-1:0]  go_long_id,
    input  logic [dis_pkg::NUM_LONG-1:0]    go_long_young,
    input  logic                            go_alu,
    input  logic [REG_W-1:0]                go_alu_dst,
    input  logic [ID_W-1:0]                 go_alu_id,
    output logic [dis_pkg::NUM_LONG-1:0]    long_busy,
    output logic [1:0]                      wb_v,
    output logic [1:0][REG_W-1:0]           wb_dst,
    output logic [1:0][ID_W-1:0]            wb_id
);
    import dis_pkg::*;

    localparam int NUM_CAND = NUM_LONG + 1;

    logic [NUM_LONG-1:0]            l_v;
    logic [NUM_LONG-1:0][REG_W-1:0] l_dst;
    logic [NUM_LONG-1:0][ID_W-1:0]  l_id;
    logic [NUM_LONG-1:0]            l_young;

    for (genvar u = 0; u < NUM_LONG; u++) begin : g_long
        dis_long_pipe #(.REG_W(REG_W), .ID_W(ID_W)) pipe_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .go         (go_long[u]),
            .go_dst     (go_long_dst[u]),
            .go_id      (go_long_id[u]),
            .go_young   (go_long_young[u]),
            .busy       (long_busy[u]),
            .done_v     (l_v[u]),
            .done_dst   (l_dst[u]),
            .done_id    (l_id[u]),
            .done_young (l_young[u])
        );
    end

    logic             a_v;
    logic [REG_W-1:0] a_dst;
    logic [ID_W-1:0]  a_id;

    // One-cycle add/subtract result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_v <= 1'b0;
        end else begin
            a_v   <= go_alu;
            a_dst <= go_alu_dst;
            a_id  <= go_alu_id;
        end
    end

    logic [NUM_CAND-1:0]            c_v;
    logic [NUM_CAND-1:0][REG_W-1:0] c_dst;
    logic [NUM_CAND-1:0][ID_W-1:0]  c_id;

    // Put the finishing results in age order, oldest first.
    always_comb begin
        logic swap;
        swap = l_v[0] && l_v[1] && l_young[0];
        c_v[0]   = swap ? l_v[1]   : l_v[0];
        c_dst[0] = swap ? l_dst[1] : l_dst[0];
        c_id[0]  = swap ? l_id[1]  : l_id[0];
        c_v[1]   = swap ? l_v[0]   : l_v[1];
        c_dst[1] = swap ? l_dst[0] : l_dst[1];
        c_id[1]  = swap ? l_id[0]  : l_id[1];
        c_v[2]   = a_v;
        c_dst[2] = a_dst;
        c_id[2]  = a_id;
    end

    // Pack the ordered results onto the two writeback ports.
    always_comb begin
        logic [1:0] n;
        n      = 2'd0;
        wb_v   = '0;
        wb_dst = '0;
        wb_id  = '0;
        for (int c = 0; c < NUM_CAND; c++) begin
            if (c_v[c] && (n < 2'd2)) begin
                wb_v[n[0]]   = 1'b1;
                wb_dst[n[0]] = c_dst[c];
                wb_id[n[0]]  = c_id[c];
                n            = n + 2'd1;
            end
        end
    end

    AST_WB_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({a_v, l_v}) <= 2);  // R10

endmodule

// File: rtl/dis_issue_ctrl.sv
`timescale 1ns/1ps
// Issue decision for the two decode slots. An instruction goes when its
// unit is free and none of its registers has a write in flight. The younger
// slot additionally needs the older one to go in the same cycle (or to be
// gone already), a different unit, no register overlap with it, and a
// latency no shorter than the older one's so results stay in order.
module dis_issue_ctrl #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [1:0]                      slot_v,
    input  logic [1:0][1:0]                 slot_op,
    input  logic [1:0][REG_W-1:0]           slot_dst,
    input  logic [1:0][REG_W-1:0]           slot_sa,
    input  logic [1:0][REG_W-1:0]           slot_sb,
    input  logic [NUM_REGS-1:0]             pend,
    input  logic [dis_pkg::NUM_LONG-1:0]    long_busy,
    output logic [1:0]                      issue
);
    import dis_pkg::*;

    logic [1:0] base_ok;
    logic       pair_dep;
    logic       order_ok;
    logic       unit_diff;

    // Per-slot readiness against unit state and in-flight writes.
    always_comb begin
        for (int k = 0; k < 2; k++) begin
            logic unit_free;
            logic regs_clear;
            case (unit_of(slot_op[k]))
                UNIT_MUL: unit_free = !long_busy[0];
                UNIT_DIV: unit_free = !long_busy[1];
                default:  unit_free = 1'b1;
            endcase
            regs_clear = !pend[slot_sa[k]] && !pend[slot_sb[k]] && !pend[slot_dst[k]];
            base_ok[k] = slot_v[k] && unit_free && regs_clear;
        end
    end

    // Hazards between the two slots when they would go together.
    always_comb begin
        pair_dep  = (slot_sa[1] == slot_dst[0]) || (slot_sb[1] == slot_dst[0])
                 || (slot_dst[1] == slot_dst[0])
                 || (slot_dst[1] == slot_sa[0]) || (slot_dst[1] == slot_sb[0]);
        order_ok  = is_long(slot_op[1]) || !is_long(slot_op[0]);
        unit_diff = unit_of(slot_op[0]) != unit_of(slot_op[1]);
    end

    // Final in-order issue decision.
    always_comb begin
        issue[0] = base_ok[0];
        issue[1] = base_ok[1]
                && (!slot_v[0] || (base_ok[0] && unit_diff && !pair_dep && order_ok));
    end

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_v[0] && issue[1]) |-> issue[0]);  // R8
    AST_ONE_PER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue == 2'b11) |-> (slot_op[0] != slot_op[1]));  // R4
    AST_NO_PAIR_WAR: assert property (@(posedge clk) disable iff (!rst_n)
        (issue == 2'b11) |-> ((slot_dst[1] != slot_sa[0]) && (slot_dst[1] != slot_sb[0])));  // R7
    AST_RAW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        issue[0] |-> (!pend[slot_sa[0]] && !pend[slot_sb[0]]));  // R5

endmodule

// File: rtl/dual_issue_scoreboard.sv
`timescale 1ns/1ps
// Dual-issue in-order scoreboard top. Connects the decode slots, the issue
// decision, the pending-write table and the execution timing model, and
// keeps the cycle counter used to time issue and writeback events.
// Assumes: NUM_REGS is a power of two; tags are unique while in flight.
module dual_issue_scoreboard #(
    parameter int NUM_REGS = 8,
    parameter int ID_W     = 6,
    parameter int CYC_W    = 32,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [1:0]            in_slot_v,
    input  logic [3:0]            in_op,
    input  logic [2*REG_W-1:0]    in_dst,
    input  logic [2*REG_W-1:0]    in_src_a,
    input  logic [2*REG_W-1:0]    in_src_b,
    input  logic [2*ID_W-1:0]     in_id,
    output logic [1:0]            iss_v,
    output logic [2*ID_W-1:0]     iss_id,
    output logic [1:0]            wb_v,
    output logic [2*REG_W-1:0]    wb_dst,
    output logic [2*ID_W-1:0]     wb_id,
    output logic [CYC_W-1:0]      cycle
);
    import dis_pkg::*;

    logic [1:0]                  slot_v;
    logic [1:0][1:0]             slot_op;
    logic [1:0][REG_W-1:0]       slot_dst;
    logic [1:0][REG_W-1:0]       slot_sa;
    logic [1:0][REG_W-1:0]       slot_sb;
    logic [1:0][ID_W-1:0]        slot_id;
    logic [1:0]                  issue;
    logic [NUM_REGS-1:0]         pend;
    logic [NUM_LONG-1:0]         long_busy;
    logic [1:0]                  wb_v_i;
    logic [1:0][REG_W-1:0]       wb_dst_i;
    logic [1:0][ID_W-1:0]        wb_id_i;

    dis_decode_slots #(.REG_W(REG_W), .ID_W(ID_W)) slots_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_slot_v (in_slot_v),
        .in_op     (in_op),
        .in_dst    (in_dst),
        .in_src_a  (in_src_a),
        .in_src_b  (in_src_b),
        .in_id     (in_id),
        .issue     (issue),
        .slot_v    (slot_v),
        .slot_op   (slot_op),
        .slot_dst  (slot_dst),
        .slot_sa   (slot_sa),
        .slot_sb   (slot_sb),
        .slot_id   (slot_id)
    );

    dis_issue_ctrl #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) issue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_v    (slot_v),
        .slot_op   (slot_op),
        .slot_dst  (slot_dst),
        .slot_sa   (slot_sa),
        .slot_sb   (slot_sb),
        .pend      (pend),
        .long_busy (long_busy),
        .issue     (issue)
    );

    dis_pend_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) pend_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_v   (issue),
        .set_idx (slot_dst),
        .clr_v   (wb_v_i),
        .clr_idx (wb_dst_i),
        .pend    (pend)
    );

    logic [NUM_LONG-1:0]            go_long;
    logic [NUM_LONG-1:0][REG_W-1:0] go_long_dst;
    logic [NUM_LONG-1:0][ID_W-1:0]  go_long_id;
    logic [NUM_LONG-1:0]            go_long_young;
    logic                           go_alu;
    logic [REG_W-1:0]               go_alu_dst;
    logic [ID_W-1:0]                go_alu_id;

    // Steer each issuing slot to its unit and mark same-cycle younger ops.
    always_comb begin
        go_long       = '0;
        go_long_dst   = '0;
        go_long_id    = '0;
        go_long_young = '0;
        go_alu        = 1'b0;
        go_alu_dst    = '0;
        go_alu_id     = '0;
        for (int k = 0; k < 2; k++) begin
            if (issue[k]) begin
                case (unit_of(slot_op[k]))
                    UNIT_MUL, UNIT_DIV: begin
                        go_long[slot_op[k][0]]       = 1'b1;
                        go_long_dst[slot_op[k][0]]   = slot_dst[k];
                        go_long_id[slot_op[k][0]]    = slot_id[k];
                        go_long_young[slot_op[k][0]] = (k == 1) && issue[0];
                    end
                    default: begin
                        go_alu     = 1'b1;
                        go_alu_dst = slot_dst[k];
                        go_alu_id  = slot_id[k];
                    end
                endcase
            end
        end
    end

    dis_exec #(.REG_W(REG_W), .ID_W(ID_W)) exec_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .go_long       (go_long),
        .go_long_dst   (go_long_dst),
        .go_long_id    (go_long_id),
        .go_long_young (go_long_young),
        .go_alu        (go_alu),
        .go_alu_dst    (go_alu_dst),
        .go_alu_id     (go_alu_id),
        .long_busy     (long_busy),
        .wb_v          (wb_v_i),
        .wb_dst        (wb_dst_i),
        .wb_id         (wb_id_i)
    );

    // Free-running cycle count since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cycle <= '0;
        else        cycle <= cycle + CYC_W'(1);
    end

    assign iss_v  = issue;
    assign iss_id = slot_id;
    assign wb_v   = wb_v_i;
    assign wb_dst = wb_dst_i;
    assign wb_id  = wb_id_i;

    AST_WB_PORT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_v[1] |-> wb_v[0]);  // R10

endmodule

// File: tb/dual_issue_scoreboard_tb_top.sv
`timescale 1ns/1ps
module dual_issue_scoreboard_tb_top;

    localparam int ID_W  = 6;
    localparam int REG_W = 3;
    localparam int NIDS  = 1 << ID_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [1:0]          in_slot_v = '0;
    logic [3:0]          in_op = '0;
    logic [2*REG_W-1:0]  in_dst = '0;
    logic [2*REG_W-1:0]  in_src_a = '0;
    logic [2*REG_W-1:0]  in_src_b = '0;
    logic [2*ID_W-1:0]   in_id = '0;
    logic [1:0]          iss_v;
    logic [2*ID_W-1:0]   iss_id;
    logic [1:0]          wb_v;
    logic [2*REG_W-1:0]  wb_dst;
    logic [2*ID_W-1:0]   wb_id;
    logic [31:0]         cycle;

    int checks = 0;
    int errors = 0;
    int iss_at  [NIDS];
    int wb_at   [NIDS];
    int wb_port [NIDS];
    int wd = 0;

    always #2.5 clk = ~clk;

    dual_issue_scoreboard dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_slot_v(in_slot_v), .in_op(in_op), .in_dst(in_dst),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_id(in_id),
        .iss_v(iss_v), .iss_id(iss_id), .wb_v(wb_v), .wb_dst(wb_dst),
        .wb_id(wb_id), .cycle(cycle)
    );

    // Record issue and writeback cycles per tag.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                if (iss_v[k]) iss_at[iss_id[k*ID_W +: ID_W]] = int'(cycle);
                if (wb_v[k]) begin
                    wb_at[wb_id[k*ID_W +: ID_W]]   = int'(cycle);
                    wb_port[wb_id[k*ID_W +: ID_W]] = k;
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic send_pair(
        input bit v0, input int op0, input int d0, input int a0, input int b0, input int id0,
        input bit v1, input int op1, input int d1, input int a1, input int b1, input int id1,
        output int acc);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_slot_v = {v1, v0};
        in_op     = {op1[1:0], op0[1:0]};
        in_dst    = {d1[2:0], d0[2:0]};
        in_src_a  = {a1[2:0], a0[2:0]};
        in_src_b  = {b1[2:0], b0[2:0]};
        in_id     = {id1[5:0], id0[5:0]};
        acc       = int'(cycle);
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (8) @(negedge clk);
    endtask

    // Independent add then multiply issue together (R3, R8).
    task automatic t_indep();
        int a;
        wait_idle();
        send_pair(1, 2, 1, 2, 3, 1, 1, 0, 4, 5, 6, 2, a);
        wait_idle();
        chk("R3", "add issue", iss_at[1], a + 1);
        chk("R8", "mul beside add issue", iss_at[2], a + 1);
        chk("R3", "add writeback", wb_at[1], a + 2);
        chk("R3", "mul writeback", wb_at[2], a + 3);
    endtask

    // Add behind a multiply slips one cycle (R9, R10).
    task automatic t_order();
        int a;
        wait_idle();
        send_pair(1, 0, 1, 2, 3, 3, 1, 2, 4, 5, 6, 4, a);
        wait_idle();
        chk("R9", "mul issue", iss_at[3], a + 1);
        chk("R9", "add held issue", iss_at[4], a + 2);
        chk("R9", "mul wb", wb_at[3], a + 3);
        chk("R9", "add wb not before mul", wb_at[4], a + 3);
        chk("R10", "older on port0", wb_port[3], 0);
        chk("R10", "younger on port1", wb_port[4], 1);
    endtask

    // Read-after-write through subtract (R5, R3).
    task automatic t_raw();
        int a;
        wait_idle();
        send_pair(1, 2, 1, 2, 3, 5, 1, 3, 4, 1, 5, 6, a);
        wait_idle();
        chk("R5", "producer wb", wb_at[5], a + 2);
        chk("R5", "consumer issue", iss_at[6], a + 3);
        chk("R3", "sub wb", wb_at[6], a + 4);
    endtask

    // Write-after-write and refused pair while busy (R6, R2).
    task automatic t_waw();
        int a;
        wait_idle();
        send_pair(1, 0, 2, 0, 1, 7, 1, 2, 2, 3, 4, 8, a);
        chk("R2", "in_ready low with slot held", int'(in_ready), 0);
        in_valid  = 1'b1;
        in_slot_v = 2'b01;
        in_op     = {2'd2, 2'd2};
        in_dst    = {3'd0, 3'd5};
        in_src_a  = {3'd0, 3'd6};
        in_src_b  = {3'd0, 3'd7};
        in_id     = {6'd0, 6'd9};
        @(negedge clk);
        in_valid  = 1'b0;
        wait_idle();
        chk("R6", "first writer wb", wb_at[7], a + 3);
        chk("R6", "second writer issue", iss_at[8], a + 4);
        chk("R6", "second writer wb", wb_at[8], a + 5);
        chk("R2", "refused pair never issues", iss_at[9], -1);
    endtask

    // Write-after-read within the pair (R7).
    task automatic t_war();
        int a;
        wait_idle();
        send_pair(1, 0, 1, 2, 3, 10, 1, 1, 2, 4, 5, 11, a);
        wait_idle();
        chk("R7", "reader issue", iss_at[10], a + 1);
        chk("R7", "writer issue next cycle", iss_at[11], a + 2);
        chk("R7", "writer wb", wb_at[11], a + 4);
    endtask

    // Multiply and divide together; port order by age (R10, R4).
    task automatic t_ports();
        int a;
        wait_idle();
        send_pair(1, 0, 1, 2, 3, 12, 1, 1, 4, 5, 6, 13, a);
        wait_idle();
        chk("R4", "mul and div same cycle", iss_at[13], iss_at[12]);
        chk("R10", "mul older port", wb_port[12], 0);
        chk("R10", "div younger port", wb_port[13], 1);
        send_pair(1, 1, 1, 2, 3, 14, 1, 0, 4, 5, 6, 15, a);
        wait_idle();
        chk("R10", "div older port", wb_port[14], 0);
        chk("R10", "mul younger port", wb_port[15], 1);
        chk("R10", "joint wb", wb_at[15], a + 3);
    endtask

    // Two multiplies: busy cycle respected (R4).
    task automatic t_busy();
        int a;
        wait_idle();
        send_pair(1, 0, 1, 2, 3, 16, 1, 0, 4, 5, 6, 17, a);
        wait_idle();
        chk("R4", "first mul issue", iss_at[16], a + 1);
        chk("R4", "second mul issue", iss_at[17], a + 3);
        chk("R4", "second mul wb", wb_at[17], a + 5);
    endtask

    // Stalled head holds back a free younger slot (R8).
    task automatic t_head();
        int a1;
        int a2;
        wait_idle();
        send_pair(1, 0, 6, 1, 2, 18, 0, 0, 0, 0, 0, 0, a1);
        send_pair(1, 2, 7, 6, 0, 19, 1, 1, 5, 1, 2, 20, a2);
        wait_idle();
        chk("R8", "second pair accept", a2, a1 + 2);
        chk("R5", "head waits for producer", iss_at[19], a1 + 4);
        chk("R8", "younger waits for head", iss_at[20], a1 + 4);
        chk("R8", "younger wb", wb_at[20], a1 + 6);
    endtask

    initial begin
        for (int i = 0; i < NIDS; i++) begin
            iss_at[i]  = -1;
            wb_at[i]   = -1;
            wb_port[i] = -1;
        end
        repeat (3) @(negedge clk);
        chk("R1", "cycle in reset", int'(cycle), 0);
        chk("R1", "in_ready in reset", int'(in_ready), 1);
        chk("R1", "issue in reset", int'(iss_v), 0);
        chk("R1", "wb in reset", int'(wb_v), 0);
        rst_n = 1'b1;
        begin
            int c0;
            @(negedge clk);
            c0 = int'(cycle);
            repeat (5) @(negedge clk);
            chk("R11", "counter step", int'(cycle), c0 + 5);
        end
        t_indep();
        t_order();
        t_raw();
        t_waw();
        t_war();
        t_ports();
        t_busy();
        t_head();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule